// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address by reading a four-level tree of translation tables from memory. A walk begins at the table whose base sits in a root-base input. At each level nine bits of the virtual address select one of 512 eight-byte entries. The entry then supplies either the base of the next table or the final frame. Each level costs one 64-bit read over a simple request/response port, and only one read is in flight at a time.

A walk ends in one of four ways:
- At the last level, which gives a 4 KB page.
- Early, at the second level (1 GB page) or the third level (2 MB page), when the entry there has its page-size flag set.
- At once, with a fault, when the input address is not canonical.
- With a fault, at the first entry whose present bit is clear.

When the walk ends, the block reports the physical address, a page-size code and the permissions combined along the path, or a fault together with the level that caused it. It then raises `done` for one cycle.

Top module: `pt_walker`

## Requirements
- R1: A request whose bits [63:47] are not all equal issues no memory read. In the cycle after it is accepted, the block shows `done` and `fault` with `fault_level` = 0.
- R2: The reads go from the top level down. The top-level read uses the root base, and each later read uses the frame from the entry before it. Each read address is {table frame, index, 3'b000}, with index VA[47:39], VA[38:30], VA[29:21] and VA[20:12] at levels 4, 3, 2 and 1.
- R3: A walk that reaches the last level gives `pa` = {entry[51:12], VA[11:0]} and `page_size` = 0. Entry bits [62:52] and [11:0] do not affect `pa`.
- R4: A present second-level entry (level 3) with bit 7 set ends the walk after two reads. It gives `page_size` = 2 and `pa` = {entry[51:30], VA[29:0]}.
- R5: A present third-level entry (level 2) with bit 7 set ends the walk after three reads. It gives `page_size` = 1 and `pa` = {entry[51:21], VA[20:0]}.
- R6: Bit 7 in a top-level entry or a last-level entry is ignored. The walk still takes all four reads and ends with a 4 KB page.
- R7: An entry with bit 0 clear ends the walk with `fault`. `fault_level` then holds the level of that entry: 4 for the top level, down to 1 for the last level.
- R8: `writable` is the AND of bit 1 over every entry read, `user_ok` is the AND of bit 2, and `exec_never` is the OR of bit 63.
- R9: Every accepted request produces exactly one `done` pulse, one cycle wide. `req_ready` is low from acceptance until that pulse has passed.
- R10: After reset the block has `req_ready` high and `done`, `fault` and `mem_rd_valid` low.
- R11: `mem_rd_valid` and `mem_rd_addr` hold steady until `mem_rd_ready` is seen. No new read is issued before the response to the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| root_base | input | 52 | Physical base of the top-level table; the low 12 bits are ignored |
| req_valid | input | 1 | A translation request is offered |
| req_ready | output | 1 | The walker is idle and takes a request |
| req_va | input | 64 | Virtual address to translate |
| mem_rd_valid | output | 1 | Read request to memory |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 52 | Physical address of the entry being read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 64 | The entry that was read |
| done | output | 1 | One-cycle pulse marking the end of a walk |
| fault | output | 1 | The walk that just ended faulted |
| fault_level | output | 3 | Faulting level (4..1), or 0 for a non-canonical address |
| pa | output | 52 | Translated physical address |
| page_size | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| writable | output | 1 | Every entry on the path allows writes |
| user_ok | output | 1 | Every entry on the path allows user access |
| exec_never | output | 1 | Some entry on the path forbids execution |

## Verification
Suppose the sequencer lands in the wrong level. This shows on the very next read request, whose address carries the wrong index field or the wrong table frame, and it shows again in the number of reads before `done`. A corrupted table base or permission accumulator stays hidden until the walk ends, and then appears on the `done` cycle in `pa` or in the permission outputs. A mishandled page-size or present bit shows as a read count that is off by at least one, or as a wrong `page_size` or `fault_level` on that same `done` cycle.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_L4    = 3'd1,
    ST_L3    = 3'd2,
    ST_L2    = 3'd3,
    ST_L1    = 3'd4,
    ST_DONE  = 3'd5,
    ST_FAULT = 3'd6
  } walk_state_t;

  // bit positions inside a table entry
  localparam int ENT_PRESENT = 0;
  localparam int ENT_WRITE   = 1;
  localparam int ENT_USER    = 2;
  localparam int ENT_BIG     = 7;
  localparam int ENT_NOEXEC  = 63;

endpackage

// File: rtl/pt_va_split.sv
module pt_va_split #(
  parameter int ADDR_W   = 64,
  parameter int IDX_W    = 9,
  parameter int PG_SHIFT = 12,
  parameter int LEVELS   = 4,
  localparam int LVL_W   = $clog2(LEVELS)
) (
  input  logic [ADDR_W-1:0] va,
  input  logic [LVL_W-1:0]  lvl,
  output logic [IDX_W-1:0]  idx
);
  logic [IDX_W-1:0] idx_arr [LEVELS];

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_idx
    assign idx_arr[lv] = va[PG_SHIFT + IDX_W*lv +: IDX_W];
  end

  assign idx = idx_arr[lvl];
endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode
  import pt_walk_pkg::*;
#(
  parameter int PTE_W    = 64,
  parameter int PA_W     = 52,
  parameter int PG_SHIFT = 12,
  localparam int FRAME_W = PA_W - PG_SHIFT
) (
  input  logic [PTE_W-1:0]   entry,
  output logic               present,
  output logic               can_write,
  output logic               can_user,
  output logic               big_page,
  output logic               no_exec,
  output logic [FRAME_W-1:0] frame
);
  assign present   = entry[ENT_PRESENT];
  assign can_write = entry[ENT_WRITE];
  assign can_user  = entry[ENT_USER];
  assign big_page  = entry[ENT_BIG];
  assign no_exec   = entry[ENT_NOEXEC];
  assign frame     = entry[PA_W-1:PG_SHIFT];
endmodule

// File: rtl/pt_pa_form.sv
module pt_pa_form #(
  parameter int PA_W     = 52,
  parameter int PG_SHIFT = 12,
  parameter int IDX_W    = 9,
  parameter int LVL_W    = 2,
  localparam int FRAME_W = PA_W - PG_SHIFT
) (
  input  logic [FRAME_W-1:0] frame,
  input  logic [PA_W-1:0]    va_low,
  input  logic [LVL_W-1:0]   size_code,
  output logic [PA_W-1:0]    pa
);
  // mask of the offset bits kept from the virtual address
  function automatic logic [PA_W-1:0] off_mask(input logic [LVL_W-1:0] sc);
    int unsigned sh;
    sh = PG_SHIFT + IDX_W * int'(sc);
    return (PA_W'(1) << sh) - PA_W'(1);
  endfunction

  logic [PA_W-1:0] mask;
  assign mask = off_mask(size_code);
  assign pa   = ({frame, {PG_SHIFT{1'b0}}} & ~mask) | (va_low & mask);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int VA_W     = 48,
  parameter int PA_W     = 52,
  parameter int PTE_W    = 64,
  parameter int IDX_W    = 9,
  parameter int PG_SHIFT = 12,
  localparam int LEVELS  = 4,
  localparam int LVL_W   = $clog2(LEVELS),
  localparam int FRAME_W = PA_W - PG_SHIFT,
  localparam int ENT_SH  = PG_SHIFT - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   root_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_va,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [PA_W-1:0]   mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic [LVL_W:0]    fault_level,
  output logic [PA_W-1:0]   pa,
  output logic [1:0]        page_size,
  output logic              writable,
  output logic              user_ok,
  output logic              exec_never
);

  function automatic logic is_canonical(input logic [ADDR_W-1:0] v);
    return (&v[ADDR_W-1:VA_W-1]) | ~(|v[ADDR_W-1:VA_W-1]);
  endfunction

  walk_state_t          state_q;
  logic                 issued_q;
  logic [ADDR_W-1:0]    va_q;
  logic [FRAME_W-1:0]   base_q;
  logic                 acc_rw_q, acc_us_q, acc_nx_q;
  logic [PA_W-1:0]      pa_q;
  logic [1:0]           size_q;
  logic [LVL_W:0]       flvl_q;

  // named internal events
  logic                 in_walk;
  logic [LVL_W-1:0]     cur_lvl;
  walk_state_t          next_lvl_st;
  logic                 req_fire, rd_fire, rsp_take, va_bad;
  logic                 entry_missing, entry_large, walk_end;

  logic [IDX_W-1:0]     idx;
  logic                 e_present, e_rw, e_us, e_big, e_nx;
  logic [FRAME_W-1:0]   e_frame;
  logic [PA_W-1:0]      pa_next;

  always_comb begin
    in_walk     = 1'b1;
    cur_lvl     = '0;
    next_lvl_st = ST_IDLE;
    unique case (state_q)
      ST_L4:   begin cur_lvl = LVL_W'(3); next_lvl_st = ST_L3; end
      ST_L3:   begin cur_lvl = LVL_W'(2); next_lvl_st = ST_L2; end
      ST_L2:   begin cur_lvl = LVL_W'(1); next_lvl_st = ST_L1; end
      ST_L1:   begin cur_lvl = LVL_W'(0); next_lvl_st = ST_DONE; end
      default: in_walk = 1'b0;
    endcase
  end

  pt_va_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PG_SHIFT(PG_SHIFT), .LEVELS(LEVELS)) u_split (
    .va(va_q), .lvl(cur_lvl), .idx(idx)
  );

  pt_entry_decode #(.PTE_W(PTE_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT)) u_dec (
    .entry(mem_rsp_data), .present(e_present), .can_write(e_rw), .can_user(e_us),
    .big_page(e_big), .no_exec(e_nx), .frame(e_frame)
  );

  pt_pa_form #(.PA_W(PA_W), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_pa (
    .frame(e_frame), .va_low(va_q[PA_W-1:0]), .size_code(cur_lvl), .pa(pa_next)
  );

  assign req_ready     = (state_q == ST_IDLE);
  assign req_fire      = req_ready && req_valid;
  assign va_bad        = !is_canonical(req_va);
  assign mem_rd_valid  = in_walk && !issued_q;
  assign mem_rd_addr   = {base_q, idx, {ENT_SH{1'b0}}};
  assign rd_fire       = mem_rd_valid && mem_rd_ready;
  assign rsp_take      = in_walk && issued_q && mem_rsp_valid;
  assign entry_missing = rsp_take && !e_present;
  assign entry_large   = rsp_take && e_present && e_big &&
                         (state_q == ST_L3 || state_q == ST_L2);
  assign walk_end      = rsp_take && e_present && (entry_large || state_q == ST_L1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
      va_q     <= '0;
      base_q   <= '0;
      acc_rw_q <= 1'b0;
      acc_us_q <= 1'b0;
      acc_nx_q <= 1'b0;
      pa_q     <= '0;
      size_q   <= '0;
      flvl_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_fire) begin
            va_q     <= req_va;
            base_q   <= root_base[PA_W-1:PG_SHIFT];
            issued_q <= 1'b0;
            acc_rw_q <= 1'b1;
            acc_us_q <= 1'b1;
            acc_nx_q <= 1'b0;
            if (va_bad) begin
              state_q <= ST_FAULT;
              flvl_q  <= '0;
            end else begin
              state_q <= ST_L4;
            end
          end
        end
        ST_L4, ST_L3, ST_L2, ST_L1: begin
          if (rd_fire) issued_q <= 1'b1;
          if (rsp_take) begin
            issued_q <= 1'b0;
            if (entry_missing) begin
              state_q <= ST_FAULT;
              flvl_q  <= {1'b0, cur_lvl} + (LVL_W+1)'(1);
            end else begin
              acc_rw_q <= acc_rw_q & e_rw;
              acc_us_q <= acc_us_q & e_us;
              acc_nx_q <= acc_nx_q | e_nx;
              if (walk_end) begin
                state_q <= ST_DONE;
                pa_q    <= pa_next;
                size_q  <= 2'(cur_lvl);
              end else begin
                state_q <= next_lvl_st;
                base_q  <= e_frame;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done        = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign fault       = (state_q == ST_FAULT);
  assign fault_level = flvl_q;
  assign pa          = pa_q;
  assign page_size   = size_q;
  assign writable    = acc_rw_q;
  assign user_ok     = acc_us_q;
  assign exec_never  = acc_nx_q;

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: a pending read keeps its address until accepted
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  // R11: no second read right after one is accepted
  a_r11_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> !mem_rd_valid);

  // R1: non-canonical input faults on the next cycle at level code 0
  a_r1_early_fault: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && va_bad |=> done && fault && fault_level == '0 && !mem_rd_valid);

  // R7: a missing entry ends in a fault
  a_r7_missing_faults: assert property (@(posedge clk) disable iff (!rst_n)
    entry_missing |=> done && fault && fault_level != '0);

  // R4/R5: a large entry ends the walk without a fault and with a large size
  a_r5_large_ends: assert property (@(posedge clk) disable iff (!rst_n)
    entry_large |=> done && !fault && page_size != 2'd0);

endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [51:0] root_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b1;
  logic [51:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        done, fault;
  logic [2:0]  fault_level;
  logic [51:0] pa;
  logic [1:0]  page_size;
  logic        writable, user_ok, exec_never;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .fault_level(fault_level), .pa(pa),
    .page_size(page_size), .writable(writable), .user_ok(user_ok), .exec_never(exec_never)
  );

  // memory model
  bit [63:0]   pmem [bit [51:0]];
  int          nrd;
  logic [51:0] got_a [8];
  logic        pending;
  logic [51:0] pend_addr;
  int          pend_cnt;
  int          lat_cfg;

  always @(posedge clk) begin
    if (!rst_n) begin
      nrd           <= 0;
      pending       <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      pend_cnt      <= 0;
      pend_addr     <= '0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_rd_valid && mem_rd_ready) begin
        got_a[nrd % 8] <= mem_rd_addr;
        nrd            <= nrd + 1;
        pending        <= 1'b1;
        pend_addr      <= mem_rd_addr;
        pend_cnt       <= lat_cfg;
      end else if (pending) begin
        if (pend_cnt == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= pmem.exists(pend_addr) ? pmem[pend_addr] : 64'd0;
          pending       <= 1'b0;
        end else begin
          pend_cnt <= pend_cnt - 1;
        end
      end
    end
  end

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // reference model
  logic [51:0] ex_a [4];
  int          ex_n;
  logic        ex_flt;
  logic [2:0]  ex_fl;
  logic [51:0] ex_pa;
  logic [1:0]  ex_sz;
  logic        ex_rw, ex_us, ex_nx;

  function automatic void ref_walk(input logic [63:0] va, input logic [51:0] root);
    logic [39:0] base;
    logic [63:0] e;
    logic [51:0] a;
    ex_n = 0; ex_flt = 0; ex_fl = 0; ex_pa = 0; ex_sz = 0;
    ex_rw = 1; ex_us = 1; ex_nx = 0;
    if (!((va[63:47] == 17'h1ffff) || (va[63:47] == 17'h0))) begin
      ex_flt = 1;
      return;
    end
    base = root[51:12];
    for (int lv = 3; lv >= 0; lv--) begin
      a = {base, va[12 + 9*lv +: 9], 3'b000};
      ex_a[ex_n] = a;
      ex_n++;
      e = pmem.exists(a) ? pmem[a] : 64'd0;
      if (!e[0]) begin
        ex_flt = 1;
        ex_fl  = 3'(lv + 1);
        return;
      end
      ex_rw = ex_rw & e[1];
      ex_us = ex_us & e[2];
      ex_nx = ex_nx | e[63];
      if (lv == 2 && e[7]) begin
        ex_sz = 2; ex_pa = {e[51:30], va[29:0]}; return;
      end
      if (lv == 1 && e[7]) begin
        ex_sz = 1; ex_pa = {e[51:21], va[20:0]}; return;
      end
      if (lv == 0) begin
        ex_sz = 0; ex_pa = {e[51:12], va[11:0]}; return;
      end
      base = e[51:12];
    end
  endfunction

  // mode: 0 random, 1 permissive 4K, 2 force 1G, 3 force 2M,
  //       6 top-level bit7 set + 4K, 10+lv not present at level lv
  task automatic build(input logic [63:0] va, input int mode, output logic [51:0] root);
    logic [39:0] tbl;
    logic [39:0] base;
    logic [51:0] a;
    logic [63:0] e;
    bit          big;
    pmem.delete();
    tbl  = 40'(16 + ($urandom % 4000) * 8);
    base = tbl;
    tbl  = tbl + 1;
    root = {base, 12'($urandom)};
    for (int lv = 3; lv >= 0; lv--) begin
      a = {base, va[12 + 9*lv +: 9], 3'b000};
      e = {$urandom, $urandom};
      if (mode == 10 + lv || (mode == 0 && ($urandom % 12) == 0)) begin
        e[0] = 1'b0;
        pmem[a] = e;
        break;
      end
      e[0] = 1'b1;
      e[7] = 1'b0;
      if (mode == 1 || mode == 6) begin
        e[1] = 1'b1; e[2] = 1'b1; e[63] = 1'b0;
      end
      big = (lv == 2 && (mode == 2 || (mode == 0 && ($urandom % 4) == 0))) ||
            (lv == 1 && (mode == 3 || (mode == 0 && ($urandom % 4) == 0)));
      if (big) begin
        e[7] = 1'b1;
        pmem[a] = e;
        break;
      end
      if (lv == 0) begin
        e[7] = (mode == 6) ? 1'b1 : 1'(($urandom));
        pmem[a] = e;
        break;
      end
      e[51:12] = tbl;
      if (lv == 3) e[7] = (mode == 6) ? 1'b1 : 1'($urandom);
      pmem[a] = e;
      base = tbl;
      tbl  = tbl + 1;
    end
  endtask

  function automatic string size_tag(input logic [1:0] sz);
    return (sz == 2) ? "R4" : (sz == 1) ? "R5" : "R3";
  endfunction

  task automatic run_walk(input logic [63:0] va, input logic [51:0] root, input string xtag);
    int          base_n;
    int          cyc;
    bit          stalled;
    logic [51:0] st_addr;
    bit          busy_seen;
    ref_walk(va, root);
    @(negedge clk);
    req_va    = va;
    root_base = root;
    req_valid = 1'b1;
    base_n    = nrd;
    lat_cfg   = int'($urandom % 3);
    chk(req_ready == 1'b1, "R9", "ready idle", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0; stalled = 0; busy_seen = 0; st_addr = '0;
    while (!done && cyc < 300) begin
      if (stalled)
        chk(mem_rd_valid && mem_rd_addr == st_addr, "R11", "held read",
            64'(mem_rd_addr), 64'(st_addr));
      if (req_ready) busy_seen = 1;
      mem_rd_ready = (($urandom % 4) != 0);
      stalled = mem_rd_valid && !mem_rd_ready;
      st_addr = mem_rd_addr;
      @(negedge clk);
      cyc++;
    end
    mem_rd_ready = 1'b1;
    if (cyc >= 300) begin
      chk(1'b0, "R9", "walk timeout", 64'(cyc), 64'd300);
      return;
    end
    chk(!busy_seen && !req_ready, "R9", "ready low while busy", 64'(busy_seen), 64'd0);
    chk(fault == ex_flt, ex_flt ? (ex_fl == 0 ? "R1" : "R7") : xtag, "fault",
        64'(fault), 64'(ex_flt));
    chk(nrd - base_n == ex_n, ex_fl == 0 && ex_flt ? "R1" : "R2", "read count",
        64'(nrd - base_n), 64'(ex_n));
    for (int k = 0; k < ex_n && k < nrd - base_n; k++)
      chk(got_a[(base_n + k) % 8] == ex_a[k], "R2", "read address",
          64'(got_a[(base_n + k) % 8]), 64'(ex_a[k]));
    if (ex_flt) begin
      chk(fault_level == ex_fl, ex_fl == 0 ? "R1" : "R7", "fault level",
          64'(fault_level), 64'(ex_fl));
    end else begin
      chk(page_size == ex_sz, xtag == "R6" ? "R6" : size_tag(ex_sz), "page size",
          64'(page_size), 64'(ex_sz));
      chk(pa == ex_pa, size_tag(ex_sz), "pa", 64'(pa), 64'(ex_pa));
      chk({writable, user_ok, exec_never} == {ex_rw, ex_us, ex_nx}, "R8", "perms",
          64'({writable, user_ok, exec_never}), 64'({ex_rw, ex_us, ex_nx}));
    end
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one cycle", 64'(done), 64'd0);
  endtask

  function automatic logic [63:0] rand_va();
    logic [47:0] v;
    v = 48'({$urandom, $urandom});
    return {{16{v[47]}}, v};
  endfunction

  initial begin
    logic [51:0] root;
    logic [63:0] va;
    void'($urandom(32'd2024));
    lat_cfg = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b1 && done == 1'b0 && fault == 1'b0 && mem_rd_valid == 1'b0,
        "R10", "reset outputs", 64'({req_ready, done, fault, mem_rd_valid}), 64'h8);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 non-canonical addresses
    va = 64'h0000_8000_0000_1000;
    build(64'h0, 1, root);
    run_walk(va, root, "R1");
    run_walk(64'hFFFF_0000_1234_5678, root, "R1");
    run_walk(64'h7FFF_FFFF_FFFF_FFFF, root, "R1");

    // R3 canonical high-half and low-half 4K pages
    va = 64'hFFFF_8123_4567_89AB; build(va, 1, root); run_walk(va, root, "R3");
    va = 64'h0000_0004_2003_10A5; build(va, 1, root); run_walk(va, root, "R3");
    // R4 1G page
    va = rand_va(); build(va, 2, root); run_walk(va, root, "R4");
    // R5 2M page
    va = rand_va(); build(va, 3, root); run_walk(va, root, "R5");
    // R6 bit7 at top and leaf ignored
    va = rand_va(); build(va, 6, root); run_walk(va, root, "R6");
    // R7 fault at each level
    for (int lv = 0; lv < 4; lv++) begin
      va = rand_va(); build(va, 10 + lv, root); run_walk(va, root, "R7");
    end

    // random mix: R2 R3 R4 R5 R7 R8 R11
    for (int n = 0; n < 300; n++) begin
      va = rand_va();
      if (($urandom % 20) == 0) va[50] = ~va[47];
      build(va, 0, root);
      run_walk(va, root, "R3");
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL R9 watchdog actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule